// File: doc/BRIEF.md
# Mixed-Width Integer Execution Unit

This block is the integer execute stage for a machine that runs randomly generated code. Each cycle it can accept one operation: a 4-bit operation code and two 64-bit operands, A and B. Two clock edges later it returns a 64-bit result C, together with a valid flag. The operation set covers the following:

- full-width add, subtract and the three bitwise operations
- the same five operations on the low 32-bit halves only, with the result zero-extended
- a right rotate of A
- five multiply forms

The multiply forms are the low and high halves of the 128-bit product, the high half in both unsigned and signed interpretation, and the full 64-bit product of the low 32-bit halves in both interpretations. Add and subtract wrap and produce no flags.

Every operation, simple or multiply, passes through the same two register stages. A valid bit travels with the data, so results come out in issue order with no gaps between them. The multiplier is built from four 32×32 partial products, which are registered in the first stage. The second stage combines them and applies sign corrections, so one set of hardware serves all five multiply forms.

Top module: `mixw_alu`

## Requirements
- R1: A clock edge with `rst_n` low clears both pipeline stages. `out_valid` is low after reset, and nothing presented on the inputs during reset produces a result.
- R2: An operation sampled with `in_valid` high at edge k appears at edge k+2 with `out_valid` high. `out_valid` is low at k+2 when `in_valid` was low at k. Back-to-back issue is allowed every cycle.
- R3: Codes 0 (add) and 1 (subtract, A−B) give the 64-bit sum or difference modulo 2^64.
- R4: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B respectively.
- R5: Codes 5 to 9 perform add, subtract, AND, OR and XOR on A[31:0] and B[31:0], in that order. C[63:32] is zero, and bits 63:32 of either operand have no effect on C.
- R6: Code 10 gives A rotated right by B[5:0] places. B[63:6] has no effect, and a count of zero returns A unchanged.
- R7: Code 11 gives the low 64 bits of the unsigned 128-bit product A×B.
- R8: Code 12 gives the high 64 bits of the unsigned 128-bit product A×B.
- R9: Code 13 gives the high 64 bits of the 128-bit product of A and B, both taken as two's-complement signed values.
- R10: Code 14 gives the 64-bit unsigned product A[31:0]×B[31:0].
- R11: Code 15 gives the 64-bit signed product of A[31:0] and B[31:0], both taken as two's-complement signed values.
- R12: In a stream of mixed operations issued on consecutive cycles, each result belongs to its own operation, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code (see R3 to R11) |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | `out_c` carries a result this cycle |
| out_c | output | 64 | Result C |

## Verification
The sign corrections in the signed high product and the signed 32-bit product are the hardest part to reach. They only matter when an operand's top bit is set, and they fail quietly when both operands are negative or one operand is the most negative value. The stimulus therefore takes every pair from a set of corner operands for every code: zero, one, all ones, the signed minimum and maximum, and the 32-bit sign boundaries. It then adds random operands whose upper halves are noise, which shows that the narrow operations ignore those halves. A final stream issues a mixed random operation on every cycle so that a multiply and a simple operation sit in the pipeline together.

// File: rtl/mixw_alu_pkg.sv
// Package: shared operation codes and decoded control for the
// mixed-width ALU. Assumes a 4-bit operation code with all 16 values used.
package mixw_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD64  = 4'd0,
        OP_SUB64  = 4'd1,
        OP_AND64  = 4'd2,
        OP_OR64   = 4'd3,
        OP_XOR64  = 4'd4,
        OP_ADD32  = 4'd5,
        OP_SUB32  = 4'd6,
        OP_AND32  = 4'd7,
        OP_OR32   = 4'd8,
        OP_XOR32  = 4'd9,
        OP_ROR64  = 4'd10,
        OP_MULLO  = 4'd11,
        OP_MULHU  = 4'd12,
        OP_MULHS  = 4'd13,
        OP_MUL32U = 4'd14,
        OP_MUL32S = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_ROR
    } simple_fn_e;

    typedef enum logic [2:0] {
        MK_LO,
        MK_HU,
        MK_HS,
        MK_W32U,
        MK_W32S
    } mul_kind_e;

    typedef struct packed {
        logic       use_mul;
        logic       narrow;
        simple_fn_e fn;
        mul_kind_e  mk;
    } alu_dec_t;

endpackage

// File: rtl/mixw_alu_decode.sv
// Module: mixw_alu_decode
// Turns the raw operation code into the control fields used by the
// simple datapath and the multiplier. Purely combinational.
// Assumes every one of the 16 codes is defined.
module mixw_alu_decode
    import mixw_alu_pkg::*;
(
    input  logic [3:0] op,
    output alu_dec_t   dec
);

    // Map each operation code onto result source, width and function.
    always_comb begin
        dec.use_mul = 1'b0;
        dec.narrow  = 1'b0;
        dec.fn      = FN_ADD;
        dec.mk      = MK_LO;
        case (alu_op_e'(op))
            OP_ADD64:  dec.fn = FN_ADD;
            OP_SUB64:  dec.fn = FN_SUB;
            OP_AND64:  dec.fn = FN_AND;
            OP_OR64:   dec.fn = FN_OR;
            OP_XOR64:  dec.fn = FN_XOR;
            OP_ADD32:  begin dec.fn = FN_ADD; dec.narrow = 1'b1; end
            OP_SUB32:  begin dec.fn = FN_SUB; dec.narrow = 1'b1; end
            OP_AND32:  begin dec.fn = FN_AND; dec.narrow = 1'b1; end
            OP_OR32:   begin dec.fn = FN_OR;  dec.narrow = 1'b1; end
            OP_XOR32:  begin dec.fn = FN_XOR; dec.narrow = 1'b1; end
            OP_ROR64:  dec.fn = FN_ROR;
            OP_MULLO:  begin dec.use_mul = 1'b1; dec.mk = MK_LO;   end
            OP_MULHU:  begin dec.use_mul = 1'b1; dec.mk = MK_HU;   end
            OP_MULHS:  begin dec.use_mul = 1'b1; dec.mk = MK_HS;   end
            OP_MUL32U: begin dec.use_mul = 1'b1; dec.mk = MK_W32U; end
            OP_MUL32S: begin dec.use_mul = 1'b1; dec.mk = MK_W32S; end
            default:   dec.fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/mixw_alu_simple.sv
// Module: mixw_alu_simple
// Add, subtract, bitwise logic and right rotate, at full or half width.
// In narrow mode both operands are cut to their low half and the result
// is zero-extended. Assumes DATA_W is an even power of two.
module mixw_alu_simple
    import mixw_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_dec_t          dec,
    output logic [DATA_W-1:0] res
);

    localparam int HALF_W  = DATA_W / 2;
    localparam int SHIFT_W = $clog2(DATA_W);

    logic [DATA_W-1:0]   opa;
    logic [DATA_W-1:0]   opb;
    logic [DATA_W-1:0]   raw;
    logic [2*DATA_W-1:0] rot_pair;

    // Gate the operand upper halves in narrow mode.
    always_comb begin
        opa = dec.narrow ? {{HALF_W{1'b0}}, a[HALF_W-1:0]} : a;
        opb = dec.narrow ? {{HALF_W{1'b0}}, b[HALF_W-1:0]} : b;
    end

    // Rotate by shifting a doubled copy of A right by the count.
    always_comb begin
        rot_pair = {a, a} >> b[SHIFT_W-1:0];
    end

    // Select the function result.
    always_comb begin
        case (dec.fn)
            FN_ADD:  raw = opa + opb;
            FN_SUB:  raw = opa - opb;
            FN_AND:  raw = opa & opb;
            FN_OR:   raw = opa | opb;
            FN_XOR:  raw = opa ^ opb;
            FN_ROR:  raw = rot_pair[DATA_W-1:0];
            default: raw = '0;
        endcase
    end

    // Zero-extend narrow results.
    always_comb begin
        res = dec.narrow ? {{HALF_W{1'b0}}, raw[HALF_W-1:0]} : raw;
    end

endmodule

// File: rtl/mixw_alu_mul_pp.sv
// Module: mixw_alu_mul_pp
// Forms the four half-width by half-width unsigned partial products of
// A and B. Each product fits exactly in DATA_W bits. Combinational.
module mixw_alu_mul_pp #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] p_ll,
    output logic [DATA_W-1:0] p_lh,
    output logic [DATA_W-1:0] p_hl,
    output logic [DATA_W-1:0] p_hh
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_lo, a_hi, b_lo, b_hi;

    // Split the operands into zero-extended halves.
    always_comb begin
        a_lo = {{HALF_W{1'b0}}, a[HALF_W-1:0]};
        a_hi = {{HALF_W{1'b0}}, a[DATA_W-1:HALF_W]};
        b_lo = {{HALF_W{1'b0}}, b[HALF_W-1:0]};
        b_hi = {{HALF_W{1'b0}}, b[DATA_W-1:HALF_W]};
    end

    // Four independent partial products.
    always_comb begin
        p_ll = a_lo * b_lo;
        p_lh = a_lo * b_hi;
        p_hl = a_hi * b_lo;
        p_hh = a_hi * b_hi;
    end

endmodule

// File: rtl/mixw_alu_mul_combine.sv
// Module: mixw_alu_mul_combine
// Sums the registered partial products into the double-width unsigned
// product and applies two's-complement corrections for the signed forms.
// A signed operand equals its unsigned value minus 2^W when its top bit
// is set, so the signed high half is the unsigned high half minus each
// operand selected by the other operand's sign. Combinational.
module mixw_alu_mul_combine
    import mixw_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] p_ll,
    input  logic [DATA_W-1:0] p_lh,
    input  logic [DATA_W-1:0] p_hl,
    input  logic [DATA_W-1:0] p_hh,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  mul_kind_e         mk,
    output logic [DATA_W-1:0] res
);

    localparam int HALF_W = DATA_W / 2;
    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] full;
    logic [DATA_W-1:0] hi_u, hi_s, corr_hi;
    logic [DATA_W-1:0] nar_s, corr_nar;

    // Assemble the unsigned double-width product.
    always_comb begin
        full = {p_hh, p_ll}
             + ({{DATA_W{1'b0}}, p_lh} << HALF_W)
             + ({{DATA_W{1'b0}}, p_hl} << HALF_W);
        hi_u = full[WIDE_W-1:DATA_W];
    end

    // Sign correction for the full-width signed high product.
    always_comb begin
        corr_hi = (a[DATA_W-1] ? b : '0) + (b[DATA_W-1] ? a : '0);
        hi_s    = hi_u - corr_hi;
    end

    // Sign correction for the half-width signed full product.
    always_comb begin
        corr_nar = (a[HALF_W-1] ? {b[HALF_W-1:0], {HALF_W{1'b0}}} : '0)
                 + (b[HALF_W-1] ? {a[HALF_W-1:0], {HALF_W{1'b0}}} : '0);
        nar_s    = p_ll - corr_nar;
    end

    // Pick the requested product form.
    always_comb begin
        case (mk)
            MK_LO:   res = full[DATA_W-1:0];
            MK_HU:   res = hi_u;
            MK_HS:   res = hi_s;
            MK_W32U: res = p_ll;
            MK_W32S: res = nar_s;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mixw_alu.sv
// Module: mixw_alu (top)
// Two-stage integer execution unit. Stage 1 registers the decoded
// control, the operands, the simple-path result and the four partial
// products. Stage 2 combines products and registers C. Every operation
// takes two edges, so results leave in issue order. Synchronous
// active-low reset clears both valid bits and the data registers.
module mixw_alu
    import mixw_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_c
);

    alu_dec_t          dec;
    logic [DATA_W-1:0] simple_res;
    logic [DATA_W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;

    logic              s1_valid;
    alu_dec_t          s1_dec;
    logic [DATA_W-1:0] s1_a, s1_b, s1_simple;
    logic [DATA_W-1:0] s1_ll, s1_lh, s1_hl, s1_hh;
    logic [DATA_W-1:0] mul_res;

    mixw_alu_decode u_decode (
        .op  (in_op),
        .dec (dec)
    );

    mixw_alu_simple #(.DATA_W(DATA_W)) u_simple (
        .a   (in_a),
        .b   (in_b),
        .dec (dec),
        .res (simple_res)
    );

    mixw_alu_mul_pp #(.DATA_W(DATA_W)) u_pp (
        .a    (in_a),
        .b    (in_b),
        .p_ll (pp_ll),
        .p_lh (pp_lh),
        .p_hl (pp_hl),
        .p_hh (pp_hh)
    );

    // Stage 1: capture control, operands, simple result and partials.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_dec    <= '0;
            s1_a      <= '0;
            s1_b      <= '0;
            s1_simple <= '0;
            s1_ll     <= '0;
            s1_lh     <= '0;
            s1_hl     <= '0;
            s1_hh     <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_dec    <= dec;
            s1_a      <= in_a;
            s1_b      <= in_b;
            s1_simple <= simple_res;
            s1_ll     <= pp_ll;
            s1_lh     <= pp_lh;
            s1_hl     <= pp_hl;
            s1_hh     <= pp_hh;
        end
    end

    mixw_alu_mul_combine #(.DATA_W(DATA_W)) u_combine (
        .p_ll (s1_ll),
        .p_lh (s1_lh),
        .p_hl (s1_hl),
        .p_hh (s1_hh),
        .a    (s1_a),
        .b    (s1_b),
        .mk   (s1_dec.mk),
        .res  (mul_res)
    );

    // Stage 2: select the result source and register C.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_c     <= '0;
        end else begin
            out_valid <= s1_valid;
            out_c     <= s1_dec.use_mul ? mul_res : s1_simple;
        end
    end

endmodule

// File: rtl/mixw_alu_check.sv
// Module: mixw_alu_check
// Property checker bound to mixw_alu. It relates the output port two
// edges after issue to the inputs of that issue. A saturating counter
// keeps $past from reaching across reset.
module mixw_alu_check
    import mixw_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_c
);

    localparam int HALF_W  = DATA_W / 2;
    localparam int SHIFT_W = $clog2(DATA_W);

    logic [1:0] since_rst;
    logic       warm;

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= 2'd0;
        else if (since_rst != 2'd2)  since_rst <= since_rst + 2'd1;
    end

    assign warm = (since_rst == 2'd2);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    assert_add_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_op, 2) == 4'(OP_ADD64))
        |-> (out_c == $past(in_a, 2) + $past(in_b, 2)));

    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_op, 2) >= 4'(OP_ADD32)
              && $past(in_op, 2) <= 4'(OP_XOR32))
        |-> (out_c[DATA_W-1:HALF_W] == '0));

    assert_rot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_op, 2) == 4'(OP_ROR64)
              && $past(in_b[SHIFT_W-1:0], 2) == '0)
        |-> (out_c == $past(in_a, 2)));

    assert_mulhu_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_op, 2) == 4'(OP_MULHU)
              && $past(in_a, 2) != '0)
        |-> (out_c < $past(in_a, 2)));

endmodule

bind mixw_alu mixw_alu_check #(.DATA_W(DATA_W)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_c     (out_c)
);

// File: tb/sim_mixw_alu.sv
`timescale 1ns/1ps
// Bench for mixw_alu. It drives inputs on the falling edge and samples
// outputs on the falling edge. The result of an issue is compared two
// falling edges later against a reference computed here in 128-bit
// arithmetic.
module sim_mixw_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'd0;
    logic [63:0] in_a = 64'd0;
    logic [63:0] in_b = 64'd0;
    logic        out_valid;
    logic [63:0] out_c;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Expected items issued one and two falling edges ago.
    logic        hv0 = 1'b0, hv1 = 1'b0;
    logic [63:0] hc0 = '0, hc1 = '0;
    logic [3:0]  ho0 = '0, ho1 = '0;
    string       ht0 = "R2", ht1 = "R2";
    string       phase_tag = "";

    always #2.5 clk = ~clk;

    mixw_alu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_c     (out_c)
    );

    function automatic logic [63:0] ref_c(input logic [3:0] op,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [127:0]        pu;
        logic signed [127:0] ps;
        logic signed [63:0]  pn;
        pu = {64'd0, a} * {64'd0, b};
        ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
        pn = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return a ^ b;
            4'd5:  return {32'd0, a[31:0] + b[31:0]};
            4'd6:  return {32'd0, a[31:0] - b[31:0]};
            4'd7:  return {32'd0, a[31:0] & b[31:0]};
            4'd8:  return {32'd0, a[31:0] | b[31:0]};
            4'd9:  return {32'd0, a[31:0] ^ b[31:0]};
            4'd10: return (a >> b[5:0]) | (b[5:0] == 6'd0 ? 64'd0 : a << (7'd64 - {1'b0, b[5:0]}));
            4'd11: return pu[63:0];
            4'd12: return pu[127:64];
            4'd13: return ps[127:64];
            4'd14: return {32'd0, a[31:0]} * {32'd0, b[31:0]};
            default: return pn;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:                   return "R3";
            4'd2, 4'd3, 4'd4:             return "R4";
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return "R5";
            4'd10:                        return "R6";
            4'd11:                        return "R7";
            4'd12:                        return "R8";
            4'd13:                        return "R9";
            4'd14:                        return "R10";
            default:                      return "R11";
        endcase
    endfunction

    function automatic logic [63:0] corner(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            5: return 64'h0000_0000_8000_0000;
            default: return 64'h0000_0000_FFFF_FFFF;
        endcase
    endfunction

    // One falling edge: check the item issued two edges ago, then drive.
    task automatic step(input logic v, input logic [3:0] op,
                        input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        n_checks++;
        if (out_valid !== hv1) begin
            n_errors++;
            $display("FAIL R2 %s out_valid actual=%b expected=%b", phase_tag, out_valid, hv1);
        end else if (hv1 && out_c !== hc1) begin
            n_errors++;
            $display("FAIL %s %s op=%0d actual=%h expected=%h", ht1, phase_tag, ho1, out_c, hc1);
        end
        in_valid = v;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        hv1 = hv0; hc1 = hc0; ho1 = ho0; ht1 = ht0;
        hv0 = v;   hc0 = ref_c(op, a, b); ho0 = op; ht0 = tag_of(op);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        // R1: inputs offered during reset must never yield a result.
        in_valid = 1'b1; in_op = 4'd11; in_a = 64'd3; in_b = 64'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_c !== 64'd0) begin
            n_errors++;
            $display("FAIL R1 during reset actual=%b/%h expected=0/0", out_valid, out_c);
        end
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 after reset actual=%b expected=0", out_valid);
        end

        // Corner operand pairs for every code.
        phase_tag = "corner";
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    step(1'b1, 4'(op), corner(i), corner(j));

        // Random operands with noisy upper halves; occasional bubbles (R2).
        phase_tag = "random";
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 100; k++)
                step(($urandom() % 8) != 0, 4'(op), rnd64(), rnd64());

        // R12: mixed operations on consecutive cycles, checked in order.
        phase_tag = "R12 mixed";
        for (int k = 0; k < 600; k++)
            step(1'b1, 4'($urandom() % 16), rnd64(), rnd64());

        // Drain the pipeline; bubbles must show out_valid low (R2).
        phase_tag = "drain";
        for (int k = 0; k < 3; k++)
            step(1'b0, 4'd0, 64'd0, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule